// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each entry maps a 20-bit virtual page number, tagged with a 2-bit address-space identifier, onto a 20-bit physical frame number and three permission bits. Pages are 4 KB and there are four address spaces. A requester presents an address-space ID and a 32-bit virtual address. One cycle after the lookup is accepted, the block returns hit or miss together with the frame and permissions. A miss raises an outstanding-miss flag, and that flag stays set until the page-table walker writes the translation back through the fill port.

Invalidation goes through a single 32-bit command word. The low two bits choose the address granularity: every entry, one 4 MB section, or one 16 KB group of four pages. Bit 31 can additionally restrict the command to one address space. A 32-bit configuration word switches on the statistics counters (bit 31) and hit-under-miss service (bit 29). Its reset value is 0x20000010. Every other configuration bit, including the five-bit line-count field, has no effect. When the buffer is full, new translations replace entries in round-robin order.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no entry is valid, `res_valid` and `miss_pending` are 0, `lk_ready` is 1 and both counters read 0.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both high. In the next cycle `res_valid` is 1. `res_hit` is 1 only if a valid entry carries both the same ID and the same page number (`lk_va[31:12]`), and then `res_pfn`/`res_perm` are that entry's values. Address bits [11:0] are ignored.
- R3: An accepted lookup that misses returns `res_hit`=0, `res_pfn`=0 and `res_perm`=0 and sets `miss_pending` from the next cycle onward.
- R4: While `miss_pending` is 1: if `cfg_word[29]`=1, `lk_ready` is 1 exactly for lookups that would hit; if `cfg_word[29]`=0, `lk_ready` is 0.
- R5: A fill clears `miss_pending`, unless a missing lookup is accepted in the same cycle. A fill whose ID and page number match a valid entry overwrites that entry. Any other fill goes to the round-robin slot, which starts at 0 and advances by one (modulo 16) per such fill. A later lookup returns the filled values.
- R6: Flush type 0 (`flush_cmd[1:0]`=0) invalidates every entry. If `flush_cmd[31]`=1, only entries whose ID equals `flush_cmd[30:29]` are invalidated; if it is 0, the ID is ignored.
- R7: Flush type 2 invalidates entries whose page bits [19:10] equal `flush_cmd[19:10]`, qualified by ID as in R6.
- R8: Flush type 3 invalidates entries whose page bits [19:2] equal `flush_cmd[19:2]`, qualified by ID as in R6.
- R9: Flush type 1 invalidates nothing.
- R10: With `cfg_word[31]`=1, every accepted hit adds one to `hit_count` and every accepted miss adds one to `miss_count`. With `cfg_word[31]`=0, both counters are 0 from the next cycle on.
- R11: A counter that reaches all ones stays at all ones while statistics remain enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Configuration: bit 31 statistics, bit 29 hit-under-miss |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 2 | Lookup address-space ID |
| lk_va | input | 32 | Lookup virtual address |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| res_valid | output | 1 | Result valid, one cycle after acceptance |
| res_hit | output | 1 | Result is a hit |
| res_pfn | output | 20 | Physical frame number of the hit |
| res_perm | output | 3 | Permissions {read, write, non-secure} of the hit |
| miss_pending | output | 1 | A miss is waiting for a fill |
| fill_valid | input | 1 | Write a translation |
| fill_asid | input | 2 | Fill address-space ID |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_pfn | input | 20 | Fill physical frame number |
| fill_perm | input | 3 | Fill permissions {read, write, non-secure} |
| flush_valid | input | 1 | Apply the flush command |
| flush_cmd | input | 32 | Flush command word |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
`lk_ready` is combinational, so it is due in the same cycle that the request is presented. The result, the counter updates and the setting of `miss_pending` all come from the same single register stage and appear one cycle after acceptance. A fill or flush changes the contents from the next cycle on. The bench drives every input on the falling edge and reads `lk_ready` shortly after it. It then reads results, flags and counters on the following falling edge, half a period after the registering edge. Each expectation comes from a bench-side model of the entries, the round-robin slot, the pending flag and the counters, which follows the requirement text.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  localparam int ASID_W     = 2;
  localparam int VPN_W      = 20;
  localparam int PFN_W      = 20;
  localparam int PERM_W     = 3;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    FL_ALL     = 2'd0,
    FL_RSVD    = 2'd1,
    FL_SECTION = 2'd2,
    FL_GROUP   = 2'd3
  } flush_kind_e;

  typedef struct packed {
    logic              vld;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } tlb_entry_t;

  function automatic logic [VPN_W-1:0] va_to_vpn(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_SHIFT];
  endfunction

  function automatic logic tag_match(input tlb_entry_t e,
                                     input logic [ASID_W-1:0] a,
                                     input logic [VPN_W-1:0] v);
    return e.vld && (e.asid == a) && (e.vpn == v);
  endfunction

  // Flush command: [1:0] granularity, [31] ID qualifier, [30:29] ID,
  // [19:10] section page bits, [19:2] group page bits.
  function automatic logic flush_match(input logic [31:0] cmd, input tlb_entry_t e);
    logic asid_ok;
    logic va_ok;
    asid_ok = !cmd[31] || (cmd[30:29] == e.asid);
    case (cmd[1:0])
      FL_ALL:     va_ok = 1'b1;
      FL_SECTION: va_ok = (cmd[19:10] == e.vpn[19:10]);
      FL_GROUP:   va_ok = (cmd[19:2] == e.vpn[19:2]);
      default:    va_ok = 1'b0;
    endcase
    return e.vld && asid_ok && va_ok;
  endfunction
endpackage

// File: rtl/xlat_tlb_flush_dec.sv
module xlat_tlb_flush_dec
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                     flush_valid,
  input  logic [31:0]              flush_cmd,
  input  tlb_entry_t [ENTRIES-1:0] ents,
  output logic [ENTRIES-1:0]       kill_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign kill_vec[i] = flush_valid && flush_match(flush_cmd, ents[i]);
  end
endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       advance,
  output logic [$clog2(ENTRIES)-1:0] slot
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)             slot <= '0;
    else if (advance) begin
      if (slot == LAST)     slot <= '0;
      else                  slot <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_tlb_sat_ctr.sv
module xlat_tlb_sat_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   count <= '0;
    else if (!enable)             count <= '0;
    else if (bump && !(&count))   count <= count + 1'b1;
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_ready,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PFN_W-1:0]  res_pfn,
  output logic [PERM_W-1:0] res_perm,
  output logic              miss_pending,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush_valid,
  input  logic [31:0]       flush_cmd,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = $clog2(ENTRIES);

  tlb_entry_t [ENTRIES-1:0] ents;
  logic [ENTRIES-1:0] lk_hit_vec;
  logic [ENTRIES-1:0] fill_hit_vec;
  logic [ENTRIES-1:0] kill_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   lk_idx;
  logic [IDX_W-1:0]   dup_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   fill_idx;
  logic [VPN_W-1:0]   lk_vpn;
  tlb_entry_t         lk_ent;
  logic               stats_en;
  logic               hum_en;
  logic               lk_hit_any;
  logic               lk_fire;
  logic               fill_dup;
  logic               unused_cfg;

  assign stats_en   = cfg_word[31];
  assign hum_en     = cfg_word[29];
  assign unused_cfg = ^{cfg_word[30], cfg_word[28:0]};
  assign lk_vpn     = va_to_vpn(lk_va);

  // Per-entry tag comparators for the lookup port and the fill port.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_hit_vec[i]   = tag_match(ents[i], lk_asid, lk_vpn);
    assign fill_hit_vec[i] = tag_match(ents[i], fill_asid, fill_vpn);
    assign valid_vec[i]    = ents[i].vld;
  end

  always_comb begin
    lk_idx  = '0;
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit_vec[i])   lk_idx  = lk_idx  | IDX_W'(i);
      if (fill_hit_vec[i]) dup_idx = dup_idx | IDX_W'(i);
    end
  end

  assign lk_hit_any = |lk_hit_vec;
  assign fill_dup   = |fill_hit_vec;
  assign lk_ent     = ents[lk_idx];
  assign lk_ready   = !miss_pending || (hum_en && lk_hit_any);
  assign lk_fire    = lk_valid && lk_ready;
  assign fill_idx   = fill_dup ? dup_idx : victim_idx;

  xlat_tlb_flush_dec #(.ENTRIES(ENTRIES)) u_flush (
    .flush_valid (flush_valid),
    .flush_cmd   (flush_cmd),
    .ents        (ents),
    .kill_vec    (kill_vec)
  );

  xlat_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (fill_valid && !fill_dup),
    .slot    (victim_idx)
  );

  // Flush clears first; a same-cycle fill then wins its own slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ents <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (kill_vec[i]) ents[i].vld <= 1'b0;
      end
      if (fill_valid) begin
        ents[fill_idx] <= '{vld: 1'b1, asid: fill_asid, vpn: fill_vpn,
                            pfn: fill_pfn, perm: fill_perm};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      res_pfn      <= '0;
      res_perm     <= '0;
      miss_pending <= 1'b0;
    end else begin
      res_valid <= lk_fire;
      if (lk_fire) begin
        res_hit  <= lk_hit_any;
        res_pfn  <= lk_hit_any ? lk_ent.pfn  : '0;
        res_perm <= lk_hit_any ? lk_ent.perm : '0;
      end
      if (lk_fire && !lk_hit_any) miss_pending <= 1'b1;
      else if (fill_valid)        miss_pending <= 1'b0;
    end
  end

  xlat_tlb_sat_ctr #(.CNT_W(CNT_W)) u_hits (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (stats_en),
    .bump   (lk_fire && lk_hit_any),
    .count  (hit_count)
  );

  xlat_tlb_sat_ctr #(.CNT_W(CNT_W)) u_misses (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (stats_en),
    .bump   (lk_fire && !lk_hit_any),
    .count  (miss_count)
  );
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stats_en,
  input logic               hum_en,
  input logic               lk_fire,
  input logic               lk_hit_any,
  input logic               lk_ready,
  input logic               res_valid,
  input logic               res_hit,
  input logic               miss_pending,
  input logic               fill_valid,
  input logic               flush_valid,
  input logic [31:0]        flush_cmd,
  input logic [ENTRIES-1:0] lk_hit_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count
);
  p_result_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> res_valid);

  p_no_result_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fire |=> !res_valid);

  p_miss_flags_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fire && !lk_hit_any) |=> (miss_pending && !res_hit));

  p_strict_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_pending && !hum_en) |-> !lk_ready);

  p_fill_clears_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(lk_fire && !lk_hit_any)) |=> !miss_pending);

  p_unique_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  p_flush_all_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && flush_cmd[1:0] == 2'd0 && !flush_cmd[31] && !fill_valid)
      |=> (valid_vec == '0));

  p_stats_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stats_en |=> (hit_count == '0 && miss_count == '0));

  p_hit_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stats_en && (&hit_count)) |=> (&hit_count));

  p_miss_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stats_en && (&miss_count)) |=> (&miss_count));
endmodule

bind xlat_tlb xlat_tlb_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stats_en     (stats_en),
  .hum_en       (hum_en),
  .lk_fire      (lk_fire),
  .lk_hit_any   (lk_hit_any),
  .lk_ready     (lk_ready),
  .res_valid    (res_valid),
  .res_hit      (res_hit),
  .miss_pending (miss_pending),
  .fill_valid   (fill_valid),
  .flush_valid  (flush_valid),
  .flush_cmd    (flush_cmd),
  .lk_hit_vec   (lk_hit_vec),
  .valid_vec    (valid_vec),
  .hit_count    (hit_count),
  .miss_count   (miss_count)
);

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;
  localparam int N = 16;
  localparam int CW = 4;
  localparam int SAT = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = 32'h2000_0010;
  logic        lk_valid = 1'b0;
  logic [1:0]  lk_asid = '0;
  logic [31:0] lk_va = '0;
  logic        lk_ready, res_valid, res_hit, miss_pending;
  logic [19:0] res_pfn;
  logic [2:0]  res_perm;
  logic        fill_valid = 1'b0;
  logic [1:0]  fill_asid = '0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush_valid = 1'b0;
  logic [31:0] flush_cmd = '0;
  logic [CW-1:0] hit_count, miss_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench-side model
  bit          m_vld [N];
  logic [1:0]  m_asid[N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  logic [2:0]  m_perm[N];
  int          m_ptr = 0;
  bit          m_pend = 0;
  bit          m_hum = 1;
  bit          m_stats = 0;
  int          m_hits = 0;
  int          m_misses = 0;

  always #4 clk = ~clk;

  xlat_tlb #(.ENTRIES(N), .CNT_W(CW)) u_xlat_tlb (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_va(lk_va), .lk_ready(lk_ready),
    .res_valid(res_valid), .res_hit(res_hit), .res_pfn(res_pfn), .res_perm(res_perm),
    .miss_pending(miss_pending),
    .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .flush_valid(flush_valid), .flush_cmd(flush_cmd),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic m_find(input logic [1:0] a, input logic [19:0] v,
                        output bit hit, output int idx);
    hit = 0;
    idx = 0;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_asid[i] == a && m_vpn[i] == v) begin
        hit = 1;
        idx = i;
      end
  endtask

  function automatic bit m_kill(input logic [31:0] c, input int i);
    bit a_ok;
    bit v_ok;
    a_ok = (c[31] == 1'b0) || (c[30:29] == m_asid[i]);
    case (c[1:0])
      2'd0:    v_ok = 1;
      2'd2:    v_ok = ((c >> 10) & 32'h3FF) == 32'(m_vpn[i] >> 10);
      2'd3:    v_ok = ((c >> 2) & 32'h3FFFF) == 32'(m_vpn[i] >> 2);
      default: v_ok = 0;
    endcase
    return m_vld[i] && a_ok && v_ok;
  endfunction

  task automatic lookup(input string req, input logic [1:0] a, input logic [31:0] va);
    bit hit;
    int idx;
    bit rdy;
    m_find(a, va[31:12], hit, idx);
    rdy = !m_pend || (m_hum && hit);
    @(negedge clk);
    lk_valid = 1'b1; lk_asid = a; lk_va = va;
    #1;
    check(req, "lk_ready", 32'(lk_ready), 32'(rdy));
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, "res_valid", 32'(res_valid), 32'(rdy));
    if (rdy) begin
      check(req, "res_hit", 32'(res_hit), 32'(hit));
      check(req, "res_pfn", 32'(res_pfn), hit ? 32'(m_pfn[idx]) : 32'h0);
      check(req, "res_perm", 32'(res_perm), hit ? 32'(m_perm[idx]) : 32'h0);
      if (m_stats) begin
        if (hit && m_hits < SAT) m_hits++;
        if (!hit && m_misses < SAT) m_misses++;
      end
      if (!hit) m_pend = 1;
    end
    if (!m_stats) begin m_hits = 0; m_misses = 0; end
    check(req, "miss_pending", 32'(miss_pending), 32'(m_pend));
    check("R10", "hit_count", 32'(hit_count), 32'(m_hits));
    check("R10", "miss_count", 32'(miss_count), 32'(m_misses));
  endtask

  task automatic fill(input logic [1:0] a, input logic [19:0] v,
                      input logic [19:0] p, input logic [2:0] pm);
    bit hit;
    int idx;
    m_find(a, v, hit, idx);
    if (!hit) begin idx = m_ptr; m_ptr = (m_ptr + 1) % N; end
    m_vld[idx] = 1; m_asid[idx] = a; m_vpn[idx] = v; m_pfn[idx] = p; m_perm[idx] = pm;
    m_pend = 0;
    @(negedge clk);
    fill_valid = 1'b1; fill_asid = a; fill_vpn = v; fill_pfn = p; fill_perm = pm;
    @(negedge clk);
    fill_valid = 1'b0;
    check("R5", "miss_pending after fill", 32'(miss_pending), 32'h0);
  endtask

  task automatic flush(input logic [31:0] c);
    for (int i = 0; i < N; i++) if (m_kill(c, i)) m_vld[i] = 0;
    @(negedge clk);
    flush_valid = 1'b1; flush_cmd = c;
    @(negedge clk);
    flush_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [31:0] c);
    @(negedge clk);
    cfg_word = c;
    m_stats = c[31];
    m_hum = c[29];
  endtask

  task automatic t_reset();
    check("R1", "res_valid", 32'(res_valid), 32'h0);
    check("R1", "miss_pending", 32'(miss_pending), 32'h0);
    check("R1", "lk_ready", 32'(lk_ready), 32'h1);
    check("R1", "hit_count", 32'(hit_count), 32'h0);
    check("R1", "miss_count", 32'(miss_count), 32'h0);
    lookup("R1", 2'd0, 32'h0000_0000);
    check("R1", "empty lookup misses", 32'(res_hit), 32'h0);
    fill(2'd0, 20'h00000, 20'h00ABC, 3'b100);
  endtask

  task automatic t_fill_hit();
    set_cfg(32'hA000_0010);
    fill(2'd1, 20'h12345, 20'hABCDE, 3'b110);
    lookup("R2", 2'd1, 32'h1234_5FFF);
    check("R2", "hit pfn", 32'(res_pfn), 32'h000A_BCDE);
    lookup("R2", 2'd1, 32'h1234_5000);
    lookup("R3", 2'd2, 32'h1234_5FFF);
    check("R3", "other ID misses", 32'(res_hit), 32'h0);
  endtask

  task automatic t_hit_under_miss();
    lookup("R4", 2'd1, 32'h1234_5123);
    lookup("R4", 2'd3, 32'h7777_7000);
    set_cfg(32'h8000_0010);
    lookup("R4", 2'd1, 32'h1234_5000);
    fill(2'd2, 20'h12345, 20'h11111, 3'b001);
    lookup("R4", 2'd1, 32'h1234_5000);
    set_cfg(32'hA000_0010);
  endtask

  task automatic t_overwrite_rr();
    fill(2'd1, 20'h12345, 20'h22222, 3'b111);
    lookup("R5", 2'd1, 32'h1234_5000);
    check("R5", "overwritten pfn", 32'(res_pfn), 32'h0002_2222);
    for (int k = 0; k < 15; k++)
      fill(2'd3, 20'h40000 + 20'(k), 20'h30000 + 20'(k), 3'b010);
    lookup("R5", 2'd3, 32'h4000_0000);
    lookup("R5", 2'd1, 32'h1234_5000);
    check("R5", "oldest entry replaced", 32'(res_hit), 32'h0);
    fill(2'd1, 20'h12345, 20'h22222, 3'b111);
  endtask

  task automatic t_flush_group();
    for (int k = 0; k < 8; k++) fill(2'd0, 20'h00100 + 20'(k), 20'h50100 + 20'(k), 3'b100);
    fill(2'd1, 20'h00104, 20'h61104, 3'b110);
    flush(32'h8000_0107);
    lookup("R8", 2'd1, 32'h0010_4000);
    check("R8", "other ID kept", 32'(res_hit), 32'h1);
    lookup("R8", 2'd0, 32'h0010_3000);
    check("R8", "neighbour group kept", 32'(res_hit), 32'h1);
    lookup("R8", 2'd0, 32'h0010_5000);
    check("R8", "group entry removed", 32'(res_hit), 32'h0);
    fill(2'd0, 20'h00105, 20'h50105, 3'b100);
  endtask

  task automatic t_flush_section();
    fill(2'd2, 20'h00400, 20'h70400, 3'b011);
    flush(32'h0000_0002);
    lookup("R7", 2'd2, 32'h0040_0000);
    check("R7", "next section kept", 32'(res_hit), 32'h1);
    lookup("R7", 2'd1, 32'h0010_4000);
    check("R7", "section entry removed", 32'(res_hit), 32'h0);
    fill(2'd1, 20'h00104, 20'h61104, 3'b110);
  endtask

  task automatic t_flush_rsvd();
    flush(32'h0000_0001);
    lookup("R9", 2'd1, 32'h0010_4000);
    check("R9", "entry survives type 1", 32'(res_hit), 32'h1);
    lookup("R9", 2'd2, 32'h0040_0000);
    check("R9", "entry survives type 1", 32'(res_hit), 32'h1);
  endtask

  task automatic t_flush_all();
    flush(32'hE000_0000);
    lookup("R6", 2'd1, 32'h1234_5000);
    check("R6", "other ID kept", 32'(res_hit), 32'h1);
    lookup("R6", 2'd3, 32'h4000_E000);
    check("R6", "ID 3 removed", 32'(res_hit), 32'h0);
    fill(2'd3, 20'h4000E, 20'h3000E, 3'b010);
    flush(32'h0000_0000);
    lookup("R6", 2'd2, 32'h0040_0000);
    check("R6", "all removed", 32'(res_hit), 32'h0);
    fill(2'd2, 20'h00400, 20'h70400, 3'b011);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 17; k++) lookup("R11", 2'd2, 32'h0040_0ABC);
    check("R11", "hit_count saturated", 32'(hit_count), 32'(SAT));
  endtask

  task automatic t_stats_off();
    set_cfg(32'h2000_0010);
    m_hits = 0;
    m_misses = 0;
    @(negedge clk);
    check("R10", "hit_count cleared", 32'(hit_count), 32'h0);
    check("R10", "miss_count cleared", 32'(miss_count), 32'h0);
    lookup("R10", 2'd2, 32'h0040_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_hit();
    t_hit_under_miss();
    t_overwrite_rr();
    t_flush_group();
    t_flush_section();
    t_flush_rsvd();
    t_flush_all();
    t_saturate();
    t_stats_off();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule